// File: doc/BRIEF.md
# Grouped Error Interrupt Controller

This block gathers eight level-sensitive device interrupt pins and twenty-three single-cycle error strobes into one 32-bit cause word. Pin causes follow their pins. Error causes latch and stay set until software clears them. Software does not clear error causes one bit at a time. It clears them in fixed families by writing a one-hot group word. A dedicated bit records that an error arrived while another error was already latched. A fixed subset of causes is treated as fatal, and these drive a separate output that no enable can mask.

Each of the eight interrupt lines also carries routing state. This is a 3-bit device number taken from a shared mapping word, and a per-line destination word with three parts: an 8-bit vector field, a 9-bit host node number, and an I/O-versus-memory select. This state goes straight out of the block, for the logic that builds interrupt messages. The register port is a plain single-cycle write strobe with a combinational read, so it has no back-pressure. No data stream crosses the block's boundary.

Top module: `grp_err_intc`

## Requirements
- R1: Cause bits 7:0 read back the current level of `dev_irq[7:0]`. They are not latched, so a deasserted pin reads 0.
- R2: A high `err_evt[i]` for one cycle sets cause bit 8+i at the next clock edge. The bit then holds until its group is cleared. The bit meanings are: 8 bus-enable fault, 9 read-request timeout, 10 retry limit, 11 master timeout, 12 PERR, 13 SERR, 14 bus parity, 15 abort, 16 SRAM parity, 17–21 link faults, 22 request FIFO overflow, 23 unsupported op, 24 bad address, 25 request fault, 26 response fault, 27 bad request packet, 28 bad response packet, 29 unexpected response, 30 size fault.
- R3: Bit 31 sets when any strobe arrives while at least one of bits 30:8 is already latched. It does not set when the strobe finds bits 30:8 all clear.
- R4: The enable register (index 1) has the same layout as the cause word. `irq` is high exactly when some cause bit and its enable bit are both 1.
- R5: Writing the clear register (index 2) clears each group whose bit is 1 in the written word. The groups are: g0 = bits 8, 10–15; g1 = bits 16, 30; g2 = bits 17–21; g3 = bits 23, 24, 25, 27; g4 = bits 9, 26, 28; g5 = bits 22, 29; g6 = bit 31. Writing 0x7F clears everything. The clear register reads as 0.
- R6: `fatal` is high whenever any of bits 13, 14 or 22–29 is latched. Enables have no effect on it, and bit 9 is not fatal.
- R7: When a strobe and a group clear for the same bit fall in the same cycle, the bit ends up set.
- R8: The device map (index 3, bits 23:0) drives `line_dev`. Line n uses bits 3n+2:3n. Bits 31:24 read as 0.
- R9: The destination word of line n is at index 4+n and has these fields: bits 7:0 drive `line_field` byte n, bits 16:8 drive the 9-bit node number `line_node`, and bit 17 drives `line_to_io[n]` (1 = I/O, 0 = memory). Bits 31:18 read as 0.
- R10: After reset, every register, every cause latch, `irq` and `fatal` are 0. Writes to the cause word (index 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_irq | input | 8 | Device interrupt pin levels |
| err_evt | input | 23 | Error strobes; bit i feeds cause bit 8+i |
| reg_addr | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Enabled-cause interrupt request |
| fatal | output | 1 | A fatal-class cause is latched |
| line_dev | output | 24 | Device number per line, 3 bits each |
| line_field | output | 64 | Vector field per line, 8 bits each |
| line_node | output | 72 | Host node number per line, 9 bits each |
| line_to_io | output | 8 | Destination select per line |

## Verification
The hardest case to reach is a strobe and a group clear landing on the same clock edge, while another error is already latched. In that case three rules act together: the set rule, the clear rule and the multi-error rule. The stimulus gets there in two steps. It first latches one cause. It then drives a write to the clear register and a strobe on that same cause in one cycle, and reads the cause word back to confirm that the cause survived and that bit 31 rose. Each clear group is also isolated. The stimulus fills every cause, including bit 31, by strobing all lines twice, clears a single group, and compares the remainder.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int NLINES    = 8;
  localparam int DEV_W     = 3;
  localparam int FIELD_W   = 8;
  localparam int NODE_W    = 9;
  localparam int DEST_W    = FIELD_W + NODE_W + 1;
  localparam int NERR      = 23;
  localparam int STAT_W    = NLINES + NERR + 1;
  localparam int MULTI_BIT = STAT_W - 1;
  localparam int NGRP      = 7;
  localparam int MAP_W     = NLINES * DEV_W;
  localparam int NREGS     = 4 + NLINES;
  localparam int ADDR_W    = $clog2(NREGS);

  localparam int IDX_STATUS = 0;
  localparam int IDX_ENABLE = 1;
  localparam int IDX_CLEAR  = 2;
  localparam int IDX_DEVMAP = 3;
  localparam int IDX_LINE0  = 4;

  localparam logic [STAT_W-1:0] FATAL_MASK = 32'h3FC0_6000;

  function automatic logic [STAT_W-1:0] grp_mask(input int g);
    logic [STAT_W-1:0] m;
    case (g)
      0:       m = 32'h0000_FD00;
      1:       m = 32'h4001_0000;
      2:       m = 32'h003E_0000;
      3:       m = 32'h0B80_0000;
      4:       m = 32'h1400_0200;
      5:       m = 32'h2040_0000;
      6:       m = 32'h8000_0000;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/gei_err_latch.sv
module gei_err_latch
  import gei_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NERR-1:0]   err_evt,
  input  logic              clr_req,
  input  logic [NGRP-1:0]   clr_grp,
  output logic [STAT_W-1:0] err_bits
);
  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] set_vec;
  logic              again;

  always_comb begin
    clr_mask = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (clr_req && clr_grp[g]) clr_mask = clr_mask | grp_mask(g);
    end
  end

  assign again   = (|err_evt) && (|err_bits[MULTI_BIT-1:NLINES]);
  assign set_vec = {again, err_evt, {NLINES{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_bits <= '0;
    else        err_bits <= (err_bits & ~clr_mask) | set_vec;
  end
endmodule

// File: rtl/gei_route_bank.sv
module gei_route_bank
  import gei_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      map_wr,
  input  logic [NLINES-1:0]         line_wr,
  input  logic [DEST_W-1:0]         wdata,
  input  logic [MAP_W-1:0]          map_wdata,
  output logic [MAP_W-1:0]          map_q,
  output logic [NLINES*DEST_W-1:0]  dest_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (map_wr) map_q <= map_wdata;
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    logic [DEST_W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          d_q <= '0;
      else if (line_wr[n]) d_q <= wdata;
    end
    assign dest_q[n*DEST_W +: DEST_W] = d_q;
  end
endmodule

// File: rtl/gei_read_mux.sv
module gei_read_mux
  import gei_pkg::*;
(
  input  logic [ADDR_W-1:0]        addr,
  input  logic [STAT_W-1:0]        status,
  input  logic [STAT_W-1:0]        enable,
  input  logic [MAP_W-1:0]         map_q,
  input  logic [NLINES*DEST_W-1:0] dest_q,
  output logic [31:0]              rdata
);
  always_comb begin
    rdata = '0;
    if (int'(addr) == IDX_STATUS)      rdata = status;
    else if (int'(addr) == IDX_ENABLE) rdata = enable;
    else if (int'(addr) == IDX_DEVMAP) rdata = 32'(map_q);
    else begin
      for (int n = 0; n < NLINES; n++) begin
        if (int'(addr) == IDX_LINE0 + n) rdata = 32'(dest_q[n*DEST_W +: DEST_W]);
      end
    end
  end
endmodule

// File: rtl/grp_err_intc.sv
module grp_err_intc
  import gei_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         dev_irq,
  input  logic [NERR-1:0]           err_evt,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  output logic                      irq,
  output logic                      fatal,
  output logic [MAP_W-1:0]          line_dev,
  output logic [NLINES*FIELD_W-1:0] line_field,
  output logic [NLINES*NODE_W-1:0]  line_node,
  output logic [NLINES-1:0]         line_to_io
);
  logic [STAT_W-1:0]        err_bits;
  logic [STAT_W-1:0]        status;
  logic [STAT_W-1:0]        en_q;
  logic                     clr_do;
  logic                     en_wr;
  logic                     map_wr;
  logic [NLINES-1:0]        line_wr;
  logic [NLINES*DEST_W-1:0] dest_q;

  assign en_wr  = reg_wr && (int'(reg_addr) == IDX_ENABLE);
  assign clr_do = reg_wr && (int'(reg_addr) == IDX_CLEAR);
  assign map_wr = reg_wr && (int'(reg_addr) == IDX_DEVMAP);

  for (genvar n = 0; n < NLINES; n++) begin : g_wdec
    assign line_wr[n] = reg_wr && (int'(reg_addr) == IDX_LINE0 + n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= reg_wdata;
  end

  gei_err_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .clr_req  (clr_do),
    .clr_grp  (reg_wdata[NGRP-1:0]),
    .err_bits (err_bits)
  );

  gei_route_bank u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_wr    (map_wr),
    .line_wr   (line_wr),
    .wdata     (reg_wdata[DEST_W-1:0]),
    .map_wdata (reg_wdata[MAP_W-1:0]),
    .map_q     (line_dev),
    .dest_q    (dest_q)
  );

  assign status = {err_bits[STAT_W-1:NLINES], dev_irq};
  assign irq    = |(status & en_q);
  assign fatal  = |(err_bits & FATAL_MASK);

  for (genvar n = 0; n < NLINES; n++) begin : g_split
    assign line_field[n*FIELD_W +: FIELD_W] = dest_q[n*DEST_W +: FIELD_W];
    assign line_node[n*NODE_W +: NODE_W]    = dest_q[n*DEST_W+FIELD_W +: NODE_W];
    assign line_to_io[n]                    = dest_q[n*DEST_W+DEST_W-1];
  end

  gei_read_mux u_rd (
    .addr   (reg_addr),
    .status (status),
    .enable (en_q),
    .map_q  (line_dev),
    .dest_q (dest_q),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/gei_checker.sv
module gei_checker
  import gei_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NERR-1:0]   err_evt,
  input logic [STAT_W-1:0] err_bits,
  input logic              clr_req,
  input logic [NGRP-1:0]   clr_grp,
  input logic [STAT_W-1:0] enable,
  input logic              irq,
  input logic              fatal
);
  p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != '0) |=> ((err_bits[MULTI_BIT-1:NLINES] & $past(err_evt)) == $past(err_evt)));

  p_multi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_evt != '0) && (err_bits[MULTI_BIT-1:NLINES] != '0)) |=> err_bits[MULTI_BIT]);

  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (clr_grp == 7'h7F) && (err_evt == '0)) |=> (err_bits == '0));

  p_fatal_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal) |-> ((($past(err_evt) << NLINES) & NERR'(0) | ({1'b0, $past(err_evt), 8'h00} & FATAL_MASK)) != '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (err_evt != '0)) |=> ((err_bits[MULTI_BIT-1:NLINES] & $past(err_evt)) == $past(err_evt)));
endmodule

bind grp_err_intc gei_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .err_evt  (err_evt),
  .err_bits (err_bits),
  .clr_req  (clr_do),
  .clr_grp  (reg_wdata[gei_pkg::NGRP-1:0]),
  .enable   (en_q),
  .irq      (irq),
  .fatal    (fatal)
);

// File: tb/test_grp_err_intc.sv
module test_grp_err_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dev_irq = '0;
  logic [22:0] err_evt = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, fatal;
  logic [23:0] line_dev;
  logic [63:0] line_field;
  logic [71:0] line_node;
  logic [7:0]  line_to_io;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic mon_go = 1'b0;

  typedef struct {
    int          sel;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  localparam logic [31:0] GM [7] = '{32'h0000_FD00, 32'h4001_0000, 32'h003E_0000,
                                     32'h0B80_0000, 32'h1400_0200, 32'h2040_0000,
                                     32'h8000_0000};

  always #10 clk = ~clk;

  grp_err_intc i_grp_err_intc (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .err_evt(err_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .fatal(fatal), .line_dev(line_dev), .line_field(line_field),
    .line_node(line_node), .line_to_io(line_to_io)
  );

  // monitor: pops expected items and compares with the observed outputs
  always @(negedge clk) begin
    if (mon_go && sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.sel)
        0: act = reg_rdata;
        1: act = {31'd0, irq};
        2: act = {31'd0, fatal};
        3: act = {8'd0, line_dev};
        4: act = {24'd0, line_field[it.idx*8 +: 8]};
        5: act = {23'd0, line_node[it.idx*9 +: 9]};
        default: act = {31'd0, line_to_io[it.idx]};
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_v(input int sel, input int idx, input int addr,
                          input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.idx = idx; it.exp = exp; it.tag = tag;
    reg_addr = 4'(addr);
    sb.push_back(it);
    mon_go = 1'b1;
    @(negedge clk);
    #1 mon_go = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input int addr, input logic [31:0] exp, input string tag);
    expect_v(0, 0, addr, exp, tag);
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    reg_addr = 4'(addr); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [22:0] m);
    err_evt = m;
    @(posedge clk); #1;
    err_evt = '0;
  endtask

  task automatic clear_and_pulse(input logic [6:0] g, input logic [22:0] m);
    reg_addr = 4'd2; reg_wdata = {25'd0, g}; reg_wr = 1'b1; err_evt = m;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0; err_evt = '0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R10 reset state
    rd(0, 32'h0, "R10 status after reset");
    rd(1, 32'h0, "R10 enable after reset");
    expect_v(1, 0, 0, 32'h0, "R10 irq after reset");
    expect_v(2, 0, 0, 32'h0, "R10 fatal after reset");
    expect_v(3, 0, 0, 32'h0, "R10 line_dev after reset");

    // R1 pins follow level; R4 enable gating
    dev_irq = 8'hA5;
    rd(0, 32'h0000_00A5, "R1 pins visible");
    expect_v(1, 0, 0, 32'h0, "R4 irq masked");
    wr(1, 32'h0000_0001);
    expect_v(1, 0, 0, 32'h1, "R4 irq enabled pin");
    dev_irq = 8'h00;
    rd(0, 32'h0, "R1 pins not sticky");
    expect_v(1, 0, 0, 32'h0, "R4 irq drops with pin");

    // R2 sticky error, R6 non-fatal timeout
    pulse(23'h000002);
    rd(0, 32'h0000_0200, "R2 timeout latched");
    expect_v(2, 0, 0, 32'h0, "R6 timeout not fatal");
    expect_v(1, 0, 0, 32'h0, "R4 error masked");
    wr(1, 32'h0000_0200);
    expect_v(1, 0, 0, 32'h1, "R4 error enabled");
    // R3 multi, R6 SERR fatal
    pulse(23'h000020);
    rd(0, 32'h8000_2200, "R3 multi with SERR");
    expect_v(2, 0, 0, 32'h1, "R6 SERR fatal");
    // R5 partial group clears
    wr(2, 32'h1);
    rd(0, 32'h8000_0200, "R5 group0 clear");
    expect_v(2, 0, 0, 32'h0, "R6 fatal drops");
    wr(2, 32'h10);
    rd(0, 32'h8000_0000, "R5 group4 clear");
    wr(2, 32'h40);
    rd(0, 32'h0, "R5 group6 clear");
    rd(2, 32'h0, "R5 clear reads zero");

    // R3 no multi from empty
    pulse(23'h7FFFFF);
    rd(0, 32'h7FFF_FF00, "R3 all errors no multi");
    expect_v(2, 0, 0, 32'h1, "R6 fatal from all");
    wr(2, 32'h7F);
    rd(0, 32'h0, "R5 clear all");

    // R5 each group isolated
    for (int g = 0; g < 7; g++) begin
      pulse(23'h7FFFFF);
      pulse(23'h7FFFFF);
      wr(2, 32'h1 << g);
      rd(0, 32'hFFFF_FF00 & ~GM[g], $sformatf("R5 group %0d alone", g));
      wr(2, 32'h7F);
    end
    rd(0, 32'h0, "R5 empty after groups");

    // R7 set wins over same-cycle clear
    pulse(23'h000001);
    clear_and_pulse(7'h01, 23'h000001);
    rd(0, 32'h8000_0100, "R7 set wins");
    wr(2, 32'h7F);

    // R6 enable-independent fatal classification
    wr(1, 32'h0);
    pulse(23'h400000);
    expect_v(2, 0, 0, 32'h0, "R6 size fault not fatal");
    pulse(23'h004000);
    expect_v(2, 0, 0, 32'h1, "R6 overflow fatal unmasked");
    wr(2, 32'h7F);

    // R10 status writes ignored
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R10 status write ignored");

    // R8 device map
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h00FF_FFFF, "R8 map width");
    wr(3, 32'h00FA_C688);
    expect_v(3, 0, 0, 32'h00FA_C688, "R8 line_dev out");
    rd(3, 32'h00FA_C688, "R8 map readback");

    // R9 destination words
    wr(7, 32'hFFFF_FFFF);
    rd(7, 32'h0003_FFFF, "R9 line3 width");
    expect_v(4, 3, 0, 32'hFF, "R9 line3 field");
    expect_v(5, 3, 0, 32'h1FF, "R9 line3 node");
    expect_v(6, 3, 0, 32'h1, "R9 line3 to io");
    wr(9, 32'h0001_2345);
    expect_v(4, 5, 0, 32'h45, "R9 line5 field");
    expect_v(5, 5, 0, 32'h123, "R9 line5 node");
    expect_v(6, 5, 0, 32'h0, "R9 line5 to memory");
    expect_v(4, 4, 0, 32'h0, "R9 line4 untouched");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule